// File: doc/BRIEF.md
# Multi-Mode 16-bit Counter/Timer

This block counts ticks of a selectable clock. It runs in one of three modes. Counter mode runs down once from a preset and flags zero. Square-wave mode toggles an output every preset ticks. Pulse mode emits a narrow pulse every preset ticks. The tick source is chosen from several inputs:
- taps of an internal prescaler on the system clock,
- an external clock input, taken directly or after division by 16,
- a one-cycle pulse from a receiver, which lets the block count received characters.

All logic runs in the system clock domain. External edges are synchronized and turned into single-cycle enables.

Software writes the 16-bit preset as two bytes and writes a control byte that holds the mode and the clock source. It then issues one-cycle start and stop strobes. The preset cannot be read back. The live count is visible. A read strobe freezes the whole 16-bit count into a snapshot register, so the two bytes of the snapshot always belong to the same instant. The ready flag and the waveform pin are plain status outputs. They carry no handshake and apply no back-pressure.

Top module: `ctmr_top`

## Requirements
- R1: After reset the live count is 0, ready is low and the output is high. Nothing counts until the first start strobe, whatever the preset and source.
- R2: Write address 2 loads the control byte. Bits [5:4] hold the mode: 00 counter, 01 square wave, 10 reserved, 11 pulse. Bits [3:0] hold the source. A start in the reserved mode loads the count but nothing counts afterwards, and the output stays high.
- R3: Source codes 0010, 0011, 0100, 0101, 0110 and 0111 give one tick every 1, 2, 16, 32, 64 and 128 system cycles respectively.
- R4: Source code 0000 gives one tick per rising edge of the external input, after synchronization. Code 0001 gives one tick per 16 such edges. Code 1100 gives one tick per rx_load pulse. Every other code gives no ticks, and the external input and rx_load then have no effect on the count.
- R5: In counter mode a start loads the preset, sets the output high and clears ready. Each tick then decrements the count. On the tick where the count becomes 0, ready sets and the output goes low. A preset of 0 sets ready and drives the output low at the start itself.
- R6: In counter mode the count keeps decrementing past 0, wrapping to 0xFFFF, while ready stays set and the output stays low. A stop freezes the count, sets the output high and clears ready.
- R7: Writing the preset (address 0 is the low byte, address 1 the high byte) never changes a running countdown. The next start loads the latest preset.
- R8: In square-wave mode a start loads the preset and sets the output high. The output toggles on every tick that finds the count at 1 or 0, and the count is reloaded from the preset on that tick. A half-period is therefore preset ticks long, and a preset of 0 behaves as 1. Ready sets when the output toggles from low to high. A stop clears ready but the waveform keeps running.
- R9: In square-wave mode a preset written during a half-period leaves that half-period unchanged and sets the length of the half-periods that follow.
- R10: In pulse mode a start loads the preset and sets the output low. Every preset ticks, the output goes high for exactly one tick period, the count reloads and ready sets. A stop clears ready without halting the pulses.
- R11: A start in any mode abandons the current cycle and begins a new one from the preset. If start and stop arrive in the same cycle, the start wins.
- R12: A rd_hi strobe copies the live count into the snapshot one clock later. The snapshot then holds that value until the next rd_hi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 preset low, 1 preset high, 2 control |
| wr_data | input | 8 | Write data |
| start_cmd | input | 1 | Start strobe |
| stop_cmd | input | 1 | Stop strobe |
| rd_hi | input | 1 | Snapshot strobe (upper-byte read) |
| ext_clk | input | 1 | Asynchronous external clock input |
| rx_load | input | 1 | One-cycle received-character pulse |
| cur_count | output | 16 | Live count |
| snap_count | output | 16 | Count captured by rd_hi |
| ready | output | 1 | Ready flag |
| wave_out | output | 1 | Waveform output |

## Verification
The bench targets the cycle where each mode reloads or hits zero. A design with an off-by-one in the reload test would stretch every half-period by one tick and shift every expected toggle. It writes the preset in the middle of a half-period and while a countdown runs. A design that reloaded immediately would shorten the current half-period or jump the running count. It also checks the wrap past zero and the same-cycle start/stop case. A wrong design would stop or re-flag at zero, or would ignore the start. Finally, it measures the spacing of ticks for each prescaler tap and counts external and receiver edges, which exposes a wrong tap index or a double-counted edge.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic [1:0] {
    MODE_COUNT  = 2'b00,
    MODE_SQUARE = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_PULSE  = 2'b11
  } ctmr_mode_e;

  localparam logic [3:0] SRC_EXT     = 4'b0000;
  localparam logic [3:0] SRC_EXT16   = 4'b0001;
  localparam logic [3:0] SRC_SYS     = 4'b0010;
  localparam logic [3:0] SRC_DIV2    = 4'b0011;
  localparam logic [3:0] SRC_DIV16   = 4'b0100;
  localparam logic [3:0] SRC_DIV32   = 4'b0101;
  localparam logic [3:0] SRC_DIV64   = 4'b0110;
  localparam logic [3:0] SRC_DIV128  = 4'b0111;
  localparam logic [3:0] SRC_RXCHR   = 4'b1100;

  localparam logic [1:0] ADDR_PRE_LO = 2'd0;
  localparam logic [1:0] ADDR_PRE_HI = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
endpackage

// File: rtl/ctmr_prescale.sv
module ctmr_prescale #(
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W:0]   tap
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign tap[0] = 1'b1;
  for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
    assign tap[k] = &div_q[k-1:0];
  end
endmodule

// File: rtl/ctmr_ext_edge.sv
module ctmr_ext_edge #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic edge_tick,
  output logic div_tick
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   edge_q;
  logic [DIV_W-1:0]       div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      edge_q <= 1'b0;
      div_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      prev_q <= sync_q[SYNC_STAGES-1];
      edge_q <= sync_q[SYNC_STAGES-1] & ~prev_q;
      if (edge_q) div_q <= div_q + 1'b1;
    end
  end

  assign edge_tick = edge_q;
  assign div_tick  = edge_q & (&div_q);

  // R4: one external edge yields exactly one tick
  p_edge_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q |=> !edge_q);
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
  import ctmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  ctmr_mode_e       mode,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             ready,
  output logic             wave
);
  logic run_q;
  logic reload;
  logic halt_now;

  assign reload   = (count <= CNT_W'(1));
  assign halt_now = stop && (mode == MODE_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ready <= 1'b0;
      wave  <= 1'b1;
      run_q <= 1'b0;
    end else if (start) begin
      count <= preset;
      run_q <= (mode != MODE_RSVD);
      ready <= (mode == MODE_COUNT) && (preset == '0);
      wave  <= !((mode == MODE_PULSE) || ((mode == MODE_COUNT) && (preset == '0)));
    end else begin
      if (stop) begin
        ready <= 1'b0;
        if (mode == MODE_COUNT) begin
          run_q <= 1'b0;
          wave  <= 1'b1;
        end
      end
      if (run_q && tick && !halt_now) begin
        unique case (mode)
          MODE_COUNT: begin
            count <= count - 1'b1;
            if (count == CNT_W'(1)) begin
              ready <= 1'b1;
              wave  <= 1'b0;
            end
          end
          MODE_SQUARE: begin
            if (reload) begin
              count <= preset;
              wave  <= !wave;
              if (!wave) ready <= 1'b1;
            end else begin
              count <= count - 1'b1;
            end
          end
          MODE_PULSE: begin
            wave <= reload;
            if (reload) begin
              count <= preset;
              ready <= 1'b1;
            end else begin
              count <= count - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6: a counter-mode stop restores the output and clears the flag
  p_stop_counter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start && mode == MODE_COUNT) |=> (wave && !ready));
  // R1: the count moves only on a tick or a start
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(count));
  // R11: a start always loads the preset
  p_start_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == $past(preset)));
  // R8: ready only rises because of a tick or a start
  p_ready_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(tick) || $past(start)));
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
  import ctmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int EXT_DIV_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              rd_hi,
  input  logic              ext_clk,
  input  logic              rx_load,
  output logic [CNT_W-1:0]  cur_count,
  output logic [CNT_W-1:0]  snap_count,
  output logic              ready,
  output logic              wave_out
);
  localparam int BYTE_W = 8;

  logic [CNT_W-1:0] preset_q;
  logic [5:0]       ctrl_q;
  logic [PRE_W:0]   tap;
  logic             ext_tick;
  logic             ext16_tick;
  logic             tick;
  logic [3:0]       src;
  ctmr_mode_e       mode;

  assign src  = ctrl_q[3:0];
  assign mode = ctmr_mode_e'(ctrl_q[5:4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset_q   <= '0;
      ctrl_q     <= '0;
      snap_count <= '0;
    end else begin
      if (wr_en) begin
        unique case (wr_addr)
          ADDR_PRE_LO: preset_q[BYTE_W-1:0]     <= wr_data;
          ADDR_PRE_HI: preset_q[CNT_W-1:BYTE_W] <= wr_data;
          ADDR_CTRL:   ctrl_q                   <= wr_data[5:0];
          default: ;
        endcase
      end
      if (rd_hi) snap_count <= cur_count;
    end
  end

  ctmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tap(tap)
  );

  ctmr_ext_edge #(.SYNC_STAGES(SYNC_STAGES), .DIV_W(EXT_DIV_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_clk),
    .edge_tick(ext_tick), .div_tick(ext16_tick)
  );

  always_comb begin
    unique case (src)
      SRC_EXT:    tick = ext_tick;
      SRC_EXT16:  tick = ext16_tick;
      SRC_SYS:    tick = tap[0];
      SRC_DIV2:   tick = tap[1];
      SRC_DIV16:  tick = tap[4];
      SRC_DIV32:  tick = tap[5];
      SRC_DIV64:  tick = tap[6];
      SRC_DIV128: tick = tap[7];
      SRC_RXCHR:  tick = rx_load;
      default:    tick = 1'b0;
    endcase
  end

  ctmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_cmd),
    .stop(stop_cmd), .mode(mode), .preset(preset_q),
    .count(cur_count), .ready(ready), .wave(wave_out)
  );

  // R12: the snapshot changes only after a read strobe
  p_snap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hi |=> $stable(snap_count));
endmodule

// File: tb/ctmr_top_test.sv
module ctmr_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic start_cmd = 1'b0, stop_cmd = 1'b0, rd_hi = 1'b0;
  logic ext_clk = 1'b0, rx_load = 1'b0;
  logic [15:0] cur_count, snap_count;
  logic ready, wave_out;

  always #5 clk = ~clk;

  ctmr_top uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .rd_hi(rd_hi), .ext_clk(ext_clk), .rx_load(rx_load),
    .cur_count(cur_count), .snap_count(snap_count),
    .ready(ready), .wave_out(wave_out)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int          at;
    logic [15:0] cnt;
    bit          use_cnt;
    logic        rdy;
    logic        wv;
    string       tag;
  } exp_t;
  exp_t q[$];

  function automatic void expect_at(int at, logic [15:0] c, bit uc,
                                    logic r, logic w, string tag);
    exp_t e;
    e.at = at; e.cnt = c; e.use_cnt = uc; e.rdy = r; e.wv = w; e.tag = tag;
    q.push_back(e);
  endfunction

  // monitor: pops expectations due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        n_chk++;
        if ((q[i].use_cnt && cur_count !== q[i].cnt) ||
            ready !== q[i].rdy || wave_out !== q[i].wv) begin
          n_fail++;
          $display("FAIL %s cycle %0d: cnt=%h rdy=%b wave=%b expected cnt=%h(%0d) rdy=%b wave=%b",
                   q[i].tag, cyc, cur_count, ready, wave_out,
                   q[i].cnt, q[i].use_cnt, q[i].rdy, q[i].wv);
        end
        q.delete(i);
      end
    end
  end

  task automatic check_val(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() != 0 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_preset(logic [15:0] v);
    wr(2'd0, v[7:0]);
    wr(2'd1, v[15:8]);
  endtask

  task automatic set_ctrl(logic [1:0] m, logic [3:0] s);
    wr(2'd2, {2'b00, m, s});
  endtask

  task automatic do_start();
    start_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0;
  endtask

  task automatic do_stop();
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
  endtask

  task automatic ext_edges(int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; idle(4);
      ext_clk = 1'b0; idle(4);
    end
  endtask

  task automatic rx_pulses(int n);
    for (int i = 0; i < n; i++) begin
      rx_load = 1'b1; idle(1);
      rx_load = 1'b0; idle(2);
    end
  endtask

  task automatic measure(logic [3:0] s, int expn, string tag);
    logic [15:0] prev;
    int c1, guard;
    set_ctrl(2'b00, s);
    set_preset(16'h1000);
    do_start();
    prev = cur_count; guard = 0;
    while (cur_count == prev && guard < 400) begin @(negedge clk); guard++; end
    c1 = cyc; prev = cur_count; guard = 0;
    while (cur_count == prev && guard < 400) begin @(negedge clk); guard++; end
    check_val(tag, cyc - c1, expn);
    do_stop();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check_val("R1 reset count", cur_count, 0);
    check_val("R1 reset ready", ready, 0);
    check_val("R1 reset wave", wave_out, 1);
    set_ctrl(2'b00, 4'b0010);
    set_preset(16'd9);
    idle(6);
    check_val("R1 no count before start", cur_count, 0);

    // R2 reserved mode
    set_ctrl(2'b10, 4'b0010);
    set_preset(16'd7);
    do_start();
    idle(5);
    check_val("R2 reserved count held", cur_count, 7);
    check_val("R2 reserved wave high", wave_out, 1);

    // R5 R6 R12 counter mode
    set_ctrl(2'b00, 4'b0010);
    set_preset(16'd5);
    s = cyc + 1;
    expect_at(s,     16'd5,    1, 0, 1, "R5 start load");
    expect_at(s + 4, 16'd1,    1, 0, 1, "R5 before zero");
    expect_at(s + 5, 16'd0,    1, 1, 0, "R5 zero");
    expect_at(s + 6, 16'hFFFF, 1, 1, 0, "R6 wrap");
    expect_at(s + 10, 16'hFFFB, 1, 1, 0, "R6 keeps counting");
    expect_at(s + 11, 16'hFFFB, 1, 0, 1, "R6 stop");
    expect_at(s + 14, 16'hFFFB, 1, 0, 1, "R6 frozen");
    do_start();
    wait_until(s + 2);
    rd_hi = 1'b1; @(negedge clk); rd_hi = 1'b0;
    check_val("R12 snapshot", snap_count, 3);
    wait_until(s + 9);
    check_val("R12 snapshot held", snap_count, 3);
    wait_until(s + 10);
    do_stop();
    drain();

    // R7 preset write during countdown
    s = cyc + 1;
    expect_at(s + 5, 16'd0, 1, 1, 0, "R7 old preset kept");
    do_start();
    set_preset(16'd9);
    drain();
    do_stop();
    s = cyc + 1;
    expect_at(s, 16'd9, 1, 0, 1, "R7 new preset at start");
    do_start();
    drain();
    do_stop();

    // R5 preset zero
    set_preset(16'd0);
    s = cyc + 1;
    expect_at(s,     16'd0,    1, 1, 0, "R5 preset zero");
    expect_at(s + 1, 16'hFFFF, 1, 1, 0, "R6 zero wraps");
    do_start();
    drain();
    do_stop();

    // R11 start beats stop
    set_preset(16'd20);
    s = cyc + 1;
    expect_at(s + 2, 16'd18, 1, 0, 1, "R11 start wins over stop");
    start_cmd = 1'b1; stop_cmd = 1'b1;
    @(negedge clk);
    start_cmd = 1'b0; stop_cmd = 1'b0;
    drain();
    do_stop();

    // R8 square wave
    set_ctrl(2'b01, 4'b0010);
    set_preset(16'd3);
    s = cyc + 1;
    expect_at(s,      16'd3, 1, 0, 1, "R8 start");
    expect_at(s + 2,  16'd1, 1, 0, 1, "R8 first half");
    expect_at(s + 3,  16'd3, 1, 0, 0, "R8 toggle low");
    expect_at(s + 6,  16'd0, 0, 1, 1, "R8 full cycle ready");
    expect_at(s + 7,  16'd0, 0, 0, 1, "R8 stop clears ready");
    expect_at(s + 9,  16'd0, 0, 0, 0, "R8 still running");
    expect_at(s + 12, 16'd0, 0, 1, 1, "R8 ready again");
    do_start();
    wait_until(s + 6);
    do_stop();
    drain();

    // R9 preset change mid half-period
    s = cyc + 1;
    expect_at(s + 3, 16'd5, 1, 0, 0, "R9 current half unchanged");
    expect_at(s + 7, 16'd0, 0, 0, 0, "R9 longer half");
    expect_at(s + 8, 16'd5, 1, 1, 1, "R9 new half length");
    do_start();
    wr(2'd0, 8'd5);
    drain();

    // R11 restart mid-cycle
    s = cyc + 1;
    expect_at(s + 2, 16'd3, 1, 0, 1, "R11 before restart");
    expect_at(s + 5, 16'd3, 1, 0, 1, "R11 restarted cycle");
    expect_at(s + 8, 16'd5, 1, 0, 0, "R11 toggle after restart");
    do_start();
    wait_until(s + 2);
    do_start();
    drain();

    // R10 pulse mode
    set_ctrl(2'b11, 4'b0010);
    set_preset(16'd4);
    s = cyc + 1;
    expect_at(s,      16'd4, 1, 0, 0, "R10 start low");
    expect_at(s + 3,  16'd1, 1, 0, 0, "R10 before pulse");
    expect_at(s + 4,  16'd4, 1, 1, 1, "R10 pulse");
    expect_at(s + 5,  16'd3, 1, 1, 0, "R10 one tick wide");
    expect_at(s + 8,  16'd4, 1, 1, 1, "R10 next pulse");
    expect_at(s + 9,  16'd3, 1, 0, 0, "R10 stop clears ready");
    expect_at(s + 12, 16'd4, 1, 1, 1, "R10 runs after stop");
    do_start();
    wait_until(s + 8);
    do_stop();
    drain();

    // R3 prescaler taps
    measure(4'b0010, 1,   "R3 sys");
    measure(4'b0011, 2,   "R3 div2");
    measure(4'b0100, 16,  "R3 div16");
    measure(4'b0101, 32,  "R3 div32");
    measure(4'b0110, 64,  "R3 div64");
    measure(4'b0111, 128, "R3 div128");

    // R4 external and receiver sources
    set_ctrl(2'b00, 4'b0000);
    set_preset(16'd100);
    do_start();
    ext_edges(3);
    idle(6);
    check_val("R4 ext edges", cur_count, 97);
    set_ctrl(2'b00, 4'b0001);
    do_start();
    ext_edges(32);
    idle(6);
    check_val("R4 ext div16", cur_count, 98);
    set_ctrl(2'b00, 4'b1100);
    do_start();
    rx_pulses(5);
    check_val("R4 rx count", cur_count, 95);
    set_ctrl(2'b00, 4'b1010);
    do_start();
    rx_pulses(4);
    ext_edges(4);
    idle(6);
    check_val("R4 unused source ignored", cur_count, 100);

    drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule